// File: doc/BRIEF.md
# MDIO Management Serial Slave

This block is the device-side end of a two-wire management link. The station drives a clock, MDC, and a shared data line, MDIO. The block samples MDIO on every rising MDC edge and parses serial frames. When a frame carries the block's own strapped 5-bit device address, the block either writes a 16-bit value into one of thirty-two registers, or returns the content of one of those registers on the line. It drives the line only while it is returning read data, using a separate output-enable pin. At all other times the line is released to the external pull-up.

After every reset the block stays silent until it has counted one unbroken run of 32 ones on MDIO. Once it has seen that run it is synchronised, and every later frame is accepted with or without a leading run of ones, until the next reset. All logic is clocked by MDC alone and has no timeouts, because MDC has no minimum frequency. The register bank is a plain array with a few non-zero reset values, so that the read path can be exercised.

Top module: `mgmt_serial_slave`

## Requirements
- R1: While rst_ni is low, and directly after it is released, mdio_oe_o is low and the block is unsynchronised.
- R2: A frame is sampled on rising MDC edges, most significant bit first, in this order: start bits 0 then 1, a 2-bit opcode, a 5-bit device address, a 5-bit register address, 2 turnaround bits and 16 data bits.
- R3: Until 32 consecutive ones have been sampled since reset, every frame is ignored: mdio_oe_o stays low and no register changes. A run of only 31 ones followed by a zero does not synchronise the block.
- R4: Once synchronised, the block accepts frames that have no preamble, and it stays synchronised until the next reset. After a new reset it is unsynchronised again.
- R5: For a read (opcode 10) that matches, mdio_oe_o stays low after the edge that samples the first turnaround bit's predecessor. After the next rising edge it goes high with mdio_o = 0. After each of the following 16 edges mdio_o carries the next data bit, MSB first. After the edge that follows, mdio_oe_o is low again.
- R6: For a write (opcode 01) that matches, the two turnaround bits are not checked. The 16 data bits are stored into the addressed register, and mdio_oe_o stays low for the whole frame.
- R7: At reset, register 0 holds 3100h, register 1 holds 7809h, register 2 holds 2000h, register 3 holds 5C01h, and all other registers hold 0000h.
- R8: A frame with opcode 00 or 11 drives nothing and writes nothing. The block skips the 18 bits after the header and then waits for a new start code.
- R9: A frame whose device address differs from phy_addr_i drives nothing and writes nothing.
- R10: Every register address from 0 to 31 selects its own register, including the highest, 31.
- R11: The start bit of the next frame may follow the last data bit directly, with no idle bits between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdio_i | input | 1 | Sampled MDIO line level |
| phy_addr_i | input | 5 | Strapped device address |
| mdio_o | output | 1 | Value driven on MDIO when enabled |
| mdio_oe_o | output | 1 | MDIO output enable, high only during read turnaround and data |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 5-bit register address giving 32 registers, and a 32-bit preamble length, with phy_addr_i strapped to 0Ch. These values bring two boundaries within reach. The first is the top register, 31. The second is the exact edge between 31 and 32 ones in the synchronisation run. The bench also covers a reset issued in mid-run, which must drop synchronisation and restore the register reset values.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HDR, S_RD_TA, S_RD_DATA, S_WR_TA, S_WR_DATA, S_SKIP
  } mgmt_state_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mgmt_preamble_det.sv
module mgmt_preamble_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdio_i,
  output logic synced_o
);
  localparam int CNT_W = $clog2(PRE_LEN + 1);

  logic [CNT_W-1:0] ones_q;
  logic             synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q   <= '0;
      synced_q <= 1'b0;
    end else if (!synced_q) begin
      if (mdio_i) begin
        if (ones_q == CNT_W'(PRE_LEN - 1)) synced_q <= 1'b1;
        ones_q <= ones_q + 1'b1;
      end else begin
        ones_q <= '0;
      end
    end
  end

  assign synced_o = synced_q;
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank #(
  parameter int DATA_W = 16,
  parameter int RA_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [RA_W-1:0]   raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int REG_CNT = 1 << RA_W;

  function automatic logic [DATA_W-1:0] init_val(input int idx);
    case (idx)
      0:       init_val = DATA_W'(16'h3100);
      1:       init_val = DATA_W'(16'h7809);
      2:       init_val = DATA_W'(16'h2000);
      3:       init_val = DATA_W'(16'h5c01);
      default: init_val = '0;
    endcase
  endfunction

  logic [DATA_W-1:0] regs_q [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_q[g] <= init_val(g);
      else if (we_i && waddr_i == RA_W'(g))       regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[raddr_i];
endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
  import mgmt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RA_W   = 5,
  parameter int PHY_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdio_i,
  input  logic              synced_i,
  input  logic [PHY_W-1:0]  phy_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [RA_W-1:0]   raddr_o,
  output logic              we_o,
  output logic [RA_W-1:0]   waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int HDR_W = 2 + PHY_W + RA_W;
  localparam int CNT_W = $clog2(DATA_W + 2);

  mgmt_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] sh_q;
  logic              oe_q, out_q, we_q;
  logic [RA_W-1:0]   waddr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [HDR_W-1:0] hdr_nx;
  logic [1:0]       op_nx;
  logic [PHY_W-1:0] phy_nx;
  logic             hit_nx;

  assign hdr_nx = {hdr_q[HDR_W-2:0], mdio_i};
  assign op_nx  = hdr_nx[HDR_W-1 -: 2];
  assign phy_nx = hdr_nx[RA_W +: PHY_W];
  assign hit_nx = (phy_nx == phy_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          // start code first bit; only once synchronised
          if (synced_i && !mdio_i) state_q <= S_START;
        end
        S_START: begin
          cnt_q   <= '0;
          state_q <= mdio_i ? S_HDR : S_IDLE;
        end
        S_HDR: begin
          hdr_q <= hdr_nx;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(HDR_W - 1)) begin
            cnt_q <= '0;
            if (hit_nx && op_nx == OP_RD)      state_q <= S_RD_TA;
            else if (hit_nx && op_nx == OP_WR) state_q <= S_WR_TA;
            else                               state_q <= S_SKIP;
          end
        end
        S_RD_TA: begin
          // first turnaround bit left undriven; drive 0 for the second
          oe_q    <= 1'b1;
          out_q   <= 1'b0;
          sh_q    <= rdata_i;
          state_q <= S_RD_DATA;
        end
        S_RD_DATA: begin
          if (cnt_q == CNT_W'(DATA_W)) begin
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= S_IDLE;
          end else begin
            out_q <= sh_q[DATA_W-1];
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_WR_TA: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            cnt_q   <= '0;
            state_q <= S_WR_DATA;
          end
        end
        S_WR_DATA: begin
          sh_q  <= {sh_q[DATA_W-2:0], mdio_i};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W - 1)) begin
            we_q    <= 1'b1;
            waddr_q <= hdr_q[RA_W-1:0];
            wdata_q <= {sh_q[DATA_W-2:0], mdio_i};
            cnt_q   <= '0;
            state_q <= S_IDLE;
          end
        end
        S_SKIP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DATA_W + 1)) begin
            cnt_q   <= '0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign raddr_o   = hdr_q[RA_W-1:0];
  assign we_o      = we_q;
  assign waddr_o   = waddr_q;
  assign wdata_o   = wdata_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
  parameter int DATA_W  = 16,
  parameter int RA_W    = 5,
  parameter int PRE_LEN = 32
) (
  input  logic       mdc_i,
  input  logic       rst_ni,
  input  logic       mdio_i,
  input  logic [4:0] phy_addr_i,
  output logic       mdio_o,
  output logic       mdio_oe_o
);
  localparam int PHY_W = 5;

  logic              synced;
  logic              reg_we;
  logic [RA_W-1:0]   reg_waddr, reg_raddr;
  logic [DATA_W-1:0] reg_wdata, reg_rdata;

  mgmt_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk_i   (mdc_i),
    .rst_ni  (rst_ni),
    .mdio_i  (mdio_i),
    .synced_o(synced)
  );

  mgmt_frame_fsm #(.DATA_W(DATA_W), .RA_W(RA_W), .PHY_W(PHY_W)) u_fsm (
    .clk_i     (mdc_i),
    .rst_ni    (rst_ni),
    .mdio_i    (mdio_i),
    .synced_i  (synced),
    .phy_addr_i(phy_addr_i),
    .rdata_i   (reg_rdata),
    .raddr_o   (reg_raddr),
    .we_o      (reg_we),
    .waddr_o   (reg_waddr),
    .wdata_o   (reg_wdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  mgmt_reg_bank #(.DATA_W(DATA_W), .RA_W(RA_W)) u_bank (
    .clk_i  (mdc_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .waddr_i(reg_waddr),
    .wdata_i(reg_wdata),
    .raddr_i(reg_raddr),
    .rdata_o(reg_rdata)
  );
endmodule

// File: rtl/mgmt_serial_slave_chk.sv
module mgmt_serial_slave_chk (
  input logic mdc_i,
  input logic rst_ni,
  input logic mdio_i,
  input logic mdio_o,
  input logic mdio_oe_o,
  input logic synced_i,
  input logic we_i
);
  AST_QUIET_UNSYNCED: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    !synced_i |-> !mdio_oe_o);                                   // R3
  AST_NO_WRITE_UNSYNCED: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    !synced_i |-> !we_i);                                        // R3
  AST_SYNC_ON_ONE: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $rose(synced_i) |-> $past(mdio_i));                          // R3
  AST_SYNC_STICKY: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    synced_i |=> synced_i);                                      // R4
  AST_TA_ZERO: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);                               // R5
  AST_DRIVE_LEN: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> $past(mdio_oe_o, 17));                  // R5
  AST_NO_WRITE_WHILE_DRIVING: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    we_i |-> !mdio_oe_o);                                        // R6
endmodule

bind mgmt_serial_slave mgmt_serial_slave_chk u_chk (
  .mdc_i    (mdc_i),
  .rst_ni   (rst_ni),
  .mdio_i   (mdio_i),
  .mdio_o   (mdio_o),
  .mdio_oe_o(mdio_oe_o),
  .synced_i (synced),
  .we_i     (reg_we)
);

// File: tb/sim_mgmt_serial_slave.sv
module sim_mgmt_serial_slave;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mdio_i = 1'b1;
  logic [4:0] phy = 5'h0c;
  logic       mdio_o, mdio_oe_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [15:0] mreg [32];
  int          ones = 0;
  bit          msync = 1'b0;

  always #10 clk = ~clk;

  mgmt_serial_slave u0 (
    .mdc_i     (clk),
    .rst_ni    (rst_ni),
    .mdio_i    (mdio_i),
    .phy_addr_i(phy),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  function automatic logic [15:0] rst_val(input int i);
    case (i)
      0: return 16'h3100;
      1: return 16'h7809;
      2: return 16'h2000;
      3: return 16'h5c01;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mreg[i] = rst_val(i);
    ones  = 0;
    msync = 1'b0;
  endtask

  task automatic check(input logic eo, input logic eout, input string req);
    total++;
    if (mdio_oe_o !== eo || (eo && mdio_o !== eout)) begin
      bad++;
      $display("FAIL %s: oe=%b out=%b expected oe=%b out=%b", req, mdio_oe_o, mdio_o, eo, eout);
    end
  endtask

  // drive one bit, clock it, compare outputs after the edge
  task automatic step(input logic v, input logic eo, input logic eout, input string req);
    mdio_i = v;
    @(posedge clk);
    if (!msync) begin
      if (v) begin
        ones++;
        if (ones >= 32) msync = 1'b1;
      end else ones = 0;
    end
    @(negedge clk);
    check(eo, eout, req);
  endtask

  task automatic ones_run(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] data, input string req);
    logic [13:0] hdr;
    bit          acc, is_rd;
    logic [15:0] rd;
    hdr   = {2'b01, op, pa, ra};
    is_rd = (op == 2'b10);
    acc   = msync && (pa == phy) && (op == 2'b10 || op == 2'b01);
    rd    = mreg[ra];
    for (int i = 13; i >= 0; i--) step(hdr[i], 1'b0, 1'b0, req);
    if (is_rd) begin
      step(1'b1, acc, 1'b0, req);
      for (int i = 15; i >= 0; i--) step(1'b1, acc, rd[i], req);
      step(1'b1, 1'b0, 1'b0, req);
    end else begin
      step(1'b1, 1'b0, 1'b0, req);
      step(1'b0, 1'b0, 1'b0, req);
      for (int i = 15; i >= 0; i--) step(data[i], 1'b0, 1'b0, req);
      if (acc) mreg[ra] = data;
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst_ni = 1'b0;
    mdio_i = 1'b1;
    model_reset();
    #1 check(1'b0, 1'b0, req);
    @(negedge clk);
    check(1'b0, 1'b0, req);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 1'b0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run=hung expected=finished");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset("R1");

    // R3: frames before synchronisation are ignored
    frame(2'b10, 5'h0c, 5'd0, 16'h0000, "R3");
    frame(2'b01, 5'h0c, 5'd5, 16'h1234, "R3");
    ones_run(31, "R3");
    frame(2'b01, 5'h0c, 5'd6, 16'h0f0e, "R3");

    ones_run(32, "R3");
    frame(2'b10, 5'h0c, 5'd1, 16'h0000, "R7");
    frame(2'b10, 5'h0c, 5'd5, 16'h0000, "R3");
    frame(2'b10, 5'h0c, 5'd6, 16'h0000, "R3");

    // R2 R6 R5 R4: write then read back with no preamble
    ones_run(2, "R4");
    frame(2'b01, 5'h0c, 5'd5, 16'ha5c3, "R6");
    ones_run(1, "R4");
    frame(2'b10, 5'h0c, 5'd5, 16'h0000, "R5");
    frame(2'b10, 5'h0c, 5'd3, 16'h0000, "R2");

    // R9: other device address
    frame(2'b10, 5'h0d, 5'd5, 16'h0000, "R9");
    frame(2'b01, 5'h1c, 5'd5, 16'h0000, "R9");
    frame(2'b10, 5'h0c, 5'd5, 16'h0000, "R9");

    // R8: invalid opcodes, back to back afterwards
    frame(2'b11, 5'h0c, 5'd5, 16'h1111, "R8");
    frame(2'b00, 5'h0c, 5'd5, 16'h2222, "R8");
    frame(2'b10, 5'h0c, 5'd5, 16'h0000, "R8");

    // R10: top register and low register
    frame(2'b01, 5'h0c, 5'd31, 16'h8001, "R10");
    frame(2'b10, 5'h0c, 5'd31, 16'h0000, "R10");
    frame(2'b10, 5'h0c, 5'd30, 16'h0000, "R10");
    frame(2'b10, 5'h0c, 5'd0, 16'h0000, "R7");

    // R11: frames with no idle between
    frame(2'b01, 5'h0c, 5'd2, 16'h3c5a, "R11");
    frame(2'b10, 5'h0c, 5'd2, 16'h0000, "R11");
    frame(2'b01, 5'h0c, 5'd2, 16'h7ffe, "R11");
    frame(2'b10, 5'h0c, 5'd2, 16'h0000, "R11");

    // R4: reset drops synchronisation and register contents
    do_reset("R1");
    frame(2'b10, 5'h0c, 5'd5, 16'h0000, "R4");
    frame(2'b01, 5'h0c, 5'd4, 16'h0f00, "R4");
    ones_run(32, "R4");
    frame(2'b10, 5'h0c, 5'd5, 16'h0000, "R7");
    frame(2'b10, 5'h0c, 5'd4, 16'h0000, "R4");
    frame(2'b10, 5'h0c, 5'd2, 16'h0000, "R7");
    ones_run(3, "R1");

    finish_run();
  end
endmodule